// File: doc/BRIEF.md
# Gated Sync Pulse Counter

This block counts rising edges on an external sync-pulse input, with a gate that a two-bit mode field opens and closes. Software writes the mode into a small four-bit register slot. The count can be read at any time. A separate output tells the input pad when to switch on its bias.

Three behaviours are selectable:
- **Closed.** The gate stays shut and the count is held.
- **Open.** The count is cleared, and every pulse is then counted for as long as the mode is kept.
- **Timed.** The count is cleared, the block waits a fixed number of timebase ticks, and then opens the gate for a fixed number of ticks. After the window it closes the gate by itself and holds the result.

The timebase is a one-cycle tick supplied from outside, every 62.5 µs in normal use. The default delay and the default window are each 27 ticks, which is about 1.69 ms.

Two rules apply at the edges of the gate:
- If the input is already high when the gate opens, that level counts as one pulse.
- If the input is high when a timed window closes, that level also counts as one pulse.

Top module: `sync_gate_counter`

## Requirements
- R1: After synchronous reset the mode reads 00, the count is 0 and `bias_en` is low.
- R2: `reg_rd_data` returns `{2'b00, mode}`. Writes to bits 3:2 have no effect. Code 11 is reserved: it reads back as 11 but behaves as closed, so no counting takes place and `bias_en` stays low.
- R3: In closed mode (code 00) the count holds its value whatever the input does, and `bias_en` is low.
- R4: While `clk_stop_req` is high the mode is forced to 00. This takes priority over a register write.
- R5: Writing code 01 clears the count. From then on, each rising edge of the synchronised input adds one, and `bias_en` is high.
- R6: The count wraps from its maximum value to 0 and keeps counting.
- R7: Writing code 10 clears the count. No pulses are counted until DELAY_TICKS ticks have passed. Pulses are then counted until a further WINDOW_TICKS ticks have passed. After that the count holds and `bias_en` stays high.
- R8: An input that is high on the first cycle the gate is open adds one. An input that is high when a timed window ends adds one.
- R9: Rewriting code 01 or 10 while that mode is already active restarts the mode's sequence from its beginning, with the count cleared.
- R10: The count never rises by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stop_req | input | 1 | Clock-stop request; forces the closed mode |
| reg_wr_en | input | 1 | Write strobe for the mode register |
| reg_wr_data | input | 4 | Write data; bits 1:0 hold the mode |
| reg_rd_data | output | 4 | Mode register read value |
| pulse_in | input | 1 | Asynchronous sync-pulse input |
| tick | input | 1 | One-cycle timebase enable |
| count | output | CNT_W | Pulse count |
| bias_en | output | 1 | Pad bias enable |

## Verification
The assertions check four things on every cycle:
- the count stays frozen while the mode is closed;
- a clock-stop request forces the mode to closed;
- a restart clears the count;
- the count steps by at most one per clock, wrapping when it passes its maximum, and a finished window holds.

Only the bench scenarios can show the following:
- the exact tick on which a timed window opens and closes;
- that pulses arriving during the delay are ignored;
- the one-pulse rule when the input is high at the open and close instants;
- the read-back of the reserved code.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        MODE_CLOSED = 2'b00,
        MODE_OPEN   = 2'b01,
        MODE_TIMED  = 2'b10,
        MODE_RSVD   = 2'b11
    } gate_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_WAIT,
        PH_WIN,
        PH_DONE
    } gate_phase_e;

    typedef struct packed {
        logic gate_open;
        logic win_done;
        logic clear;
    } gate_ctl_t;

    typedef struct packed {
        logic rise;
        logic level;
    } pin_state_t;

    localparam int REG_W = 4;

    function automatic logic mode_is_active(input logic [1:0] m);
        return (m == MODE_OPEN) || (m == MODE_TIMED);
    endfunction

endpackage

// File: rtl/sgc_input_sync.sv
module sgc_input_sync
    import sgc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    output pin_state_t state
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        state.level = sync_q[STAGES-1];
        state.rise  = sync_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/sgc_gate_seq.sv
module sgc_gate_seq
    import sgc_pkg::*;
#(
    parameter int DELAY_TICKS  = 27,
    parameter int WINDOW_TICKS = 27
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_stop,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       tick,
    output logic [1:0] mode,
    output gate_ctl_t  ctl,
    output logic       bias_en
);
    localparam int MAX_TICKS = (DELAY_TICKS > WINDOW_TICKS) ? DELAY_TICKS : WINDOW_TICKS;
    localparam int TCNT_W    = $clog2(MAX_TICKS + 1);
    localparam logic [TCNT_W-1:0] DELAY_LAST  = TCNT_W'(DELAY_TICKS - 1);
    localparam logic [TCNT_W-1:0] WINDOW_LAST = TCNT_W'(WINDOW_TICKS - 1);

    logic [1:0]        mode_q;
    gate_phase_e       phase_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic              wr_ok;

    assign wr_ok = wr_en && !clk_stop;

    always_ff @(posedge clk) begin
        if (rst || clk_stop) begin
            mode_q  <= MODE_CLOSED;
            phase_q <= PH_IDLE;
            tcnt_q  <= '0;
        end else if (wr_ok) begin
            mode_q <= wr_mode;
            tcnt_q <= '0;
            case (wr_mode)
                MODE_OPEN:  phase_q <= PH_OPEN;
                MODE_TIMED: phase_q <= PH_WAIT;
                default:    phase_q <= PH_IDLE;
            endcase
        end else if (tick) begin
            case (phase_q)
                PH_WAIT: begin
                    if (tcnt_q == DELAY_LAST) begin
                        phase_q <= PH_WIN;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_WIN: begin
                    if (tcnt_q == WINDOW_LAST) begin
                        phase_q <= PH_DONE;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: tcnt_q <= tcnt_q;
            endcase
        end
    end

    always_comb begin
        ctl.gate_open = (phase_q == PH_OPEN) || (phase_q == PH_WIN);
        ctl.win_done  = (phase_q == PH_DONE);
        ctl.clear     = wr_ok && mode_is_active(wr_mode);
        mode          = mode_q;
        bias_en       = mode_is_active(mode_q);
    end

    // R4: a clock-stop request leaves the block closed and unbiased
    a_r4_stop_closes: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> (mode == MODE_CLOSED) && !bias_en);

    // R7: a finished window stays finished until rewritten
    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !wr_en && !clk_stop) |=> (phase_q == PH_DONE));
endmodule

// File: rtl/sgc_counter.sv
module sgc_counter
    import sgc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  gate_ctl_t        ctl,
    input  pin_state_t       pin,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic             open_q;
    logic             open_edge;
    logic             close_edge;
    logic             inc;

    always_comb begin
        open_edge  = ctl.gate_open && !open_q;
        close_edge = !ctl.gate_open && open_q && ctl.win_done;
        inc        = (ctl.gate_open && pin.rise)
                   || ((open_edge || close_edge) && pin.level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (ctl.clear) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else begin
            open_q <= ctl.gate_open;
            if (inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R6: the maximum value rolls over to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1 && inc && !ctl.clear) |=> (cnt_q == '0));

    // R10: at most one step per clock
    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));
endmodule

// File: rtl/sync_gate_counter.sv
module sync_gate_counter
    import sgc_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int DELAY_TICKS  = 27,
    parameter int WINDOW_TICKS = 27,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_stop_req,
    input  logic             reg_wr_en,
    input  logic [3:0]       reg_wr_data,
    output logic [3:0]       reg_rd_data,
    input  logic             pulse_in,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             bias_en
);
    logic [1:0] mode;
    gate_ctl_t  ctl;
    pin_state_t pin;

    sgc_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (pulse_in),
        .state (pin)
    );

    sgc_gate_seq #(.DELAY_TICKS(DELAY_TICKS), .WINDOW_TICKS(WINDOW_TICKS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clk_stop (clk_stop_req),
        .wr_en    (reg_wr_en),
        .wr_mode  (reg_wr_data[1:0]),
        .tick     (tick),
        .mode     (mode),
        .ctl      (ctl),
        .bias_en  (bias_en)
    );

    sgc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .pin   (pin),
        .count (count)
    );

    assign reg_rd_data = {{(REG_W-2){1'b0}}, mode};

    // R3: a closed or reserved mode holds the count
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr_en && !mode_is_active(reg_rd_data[1:0])) |=> $stable(count));

    // R9: writing an active code restarts with a cleared count
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !clk_stop_req && mode_is_active(reg_wr_data[1:0])) |=> (count == '0));
endmodule

// File: tb/tb_sync_gate_counter.sv
module tb_sync_gate_counter;
    localparam int CNT_W = 8;
    localparam int DLY   = 27;
    localparam int WIN   = 27;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clk_stop_req = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [3:0]       reg_wr_data = '0;
    logic [3:0]       reg_rd_data;
    logic             pulse_in = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] count;
    logic             bias_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int    sel;
        int    exp;
        string req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    sync_gate_counter #(.CNT_W(CNT_W), .DELAY_TICKS(DLY), .WINDOW_TICKS(WIN)) dut (
        .clk          (clk),
        .rst          (rst),
        .clk_stop_req (clk_stop_req),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_data  (reg_rd_data),
        .pulse_in     (pulse_in),
        .tick         (tick),
        .count        (count),
        .bias_en      (bias_en)
    );

    // monitor: pops expected items and compares on the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = int'(count);
                1:       act = int'(bias_en);
                default: act = int'(reg_rd_data);
            endcase
            checks++;
            if (act != it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_item(input int sel, input int exp, input string req);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        cyc(1);
    endtask

    task automatic wr(input logic [3:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        cyc(1);
        reg_wr_en   = 1'b0;
        cyc(1);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pulse_in = 1'b1;
            cyc(2);
            pulse_in = 1'b0;
            cyc(3);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(3);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        expect_item(0, 0, "R1");
        expect_item(1, 0, "R1");
        expect_item(2, 0, "R1");

        // R2 upper bits ignored, R5 open mode
        wr(4'b1101);
        expect_item(2, 1, "R2");
        expect_item(1, 1, "R5");
        pulses(5);
        expect_item(0, 5, "R5");

        // R3 closed freezes
        wr(4'b0000);
        pulses(4);
        expect_item(0, 5, "R3");
        expect_item(1, 0, "R3");

        // R9 rewrite open clears
        wr(4'b0001);
        pulses(2);
        wr(4'b0001);
        expect_item(0, 0, "R9");

        // R6 wrap
        pulses(255);
        expect_item(0, 255, "R6");
        pulses(1);
        expect_item(0, 0, "R6");
        pulses(2);
        expect_item(0, 2, "R6");

        // R8 input high when gate opens in open mode
        wr(4'b0000);
        pulse_in = 1'b1;
        cyc(4);
        wr(4'b0001);
        cyc(2);
        expect_item(0, 1, "R8");
        pulse_in = 1'b0;
        cyc(3);

        // R7 timed window
        wr(4'b0010);
        expect_item(0, 0, "R7");
        pulses(3);
        ticks(DLY - 1);
        pulses(2);
        expect_item(0, 0, "R7");
        ticks(1);
        pulses(4);
        expect_item(0, 4, "R7");
        ticks(WIN);
        pulses(3);
        expect_item(0, 4, "R7");
        expect_item(1, 1, "R7");

        // R8 input high at window open and at window close
        wr(4'b0010);
        ticks(DLY - 1);
        pulse_in = 1'b1;
        cyc(4);
        ticks(1);
        cyc(2);
        expect_item(0, 1, "R8");
        pulse_in = 1'b0;
        cyc(3);
        pulse_in = 1'b1;
        cyc(4);
        expect_item(0, 2, "R8");
        ticks(WIN);
        cyc(2);
        expect_item(0, 3, "R8");
        pulse_in = 1'b0;
        cyc(3);

        // R9 rewrite timed mid-window restarts the delay
        wr(4'b0010);
        ticks(DLY);
        pulses(2);
        wr(4'b0010);
        expect_item(0, 0, "R9");
        pulses(2);
        expect_item(0, 0, "R9");

        // R4 clock stop beats a write
        wr(4'b0001);
        pulses(3);
        clk_stop_req = 1'b1;
        reg_wr_en    = 1'b1;
        reg_wr_data  = 4'b0001;
        cyc(1);
        reg_wr_en    = 1'b0;
        cyc(1);
        expect_item(2, 0, "R4");
        expect_item(1, 0, "R4");
        pulses(2);
        expect_item(0, 3, "R4");
        clk_stop_req = 1'b0;
        cyc(1);

        // R2 reserved code reads back 3 and behaves closed
        wr(4'b0011);
        expect_item(2, 3, "R2");
        expect_item(1, 0, "R2");
        pulses(3);
        expect_item(0, 3, "R2");

        // R10 single open-edge pulse gives exactly one count
        wr(4'b0001);
        pulses(1);
        expect_item(0, 1, "R10");

        cyc(3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule